// File: doc/BRIEF.md
# Inter-processor software interrupt generator

This block lets any processor interface in a multi-processor cluster post a software interrupt to any set of interfaces, including itself. A single write to the trigger register names both the list of destination interfaces and the interrupt number. Each destination keeps a private record for that interrupt number, and the record marks which interface sent it, so several senders of the same interrupt number stay distinguishable.

Every interface sees only its own records, through a banked window of four 32-bit words. Each word holds four byte lanes, one lane per interrupt number, and one bit per sending interface within a lane. Through the same window, an interface can drop records by writing ones to a clear alias, or add records by writing ones to the set alias. A flat output vector tells downstream arbitration logic which interrupt numbers are pending at each interface. Acknowledge and priority handling live outside this block.

Top module: `sgi_gen`

## Requirements
- R1: After reset every record is empty: `pend_o` is all zeros and every window read returns 0.
- R2: A write to byte address 0x20 by interface `wr_if` takes the destination list from data bits [23:16] (bit 16+t selects interface t) and the interrupt number from bits [3:0]. One cycle later, bit `wr_if` is set in that number's lane of each selected interface's bank. All other data bits are ignored.
- R3: A trigger write with an empty destination list (bits [23:16] all zero) changes no record.
- R4: A trigger write leaves the banks of interfaces outside the destination list unchanged.
- R5: A read with `rd_if` = i and `rd_addr` = 0x00/0x04/0x08/0x0C, or the alias 0x10/0x14/0x18/0x1C, returns interface i's records combinationally. Word w = addr[3:2], byte lane b holds interrupt number 4w+b, and bit k of the lane means interface k sent it. A read in the same cycle as a write returns the state from before that write. Any other read address returns 0.
- R6: A write by interface i to 0x10+4w clears, in bank i only, each record whose bit is 1 in the written data (lane layout as in R5). Records whose bits are 0 are kept.
- R7: A write by interface i to 0x00+4w adds, in bank i only, each record whose bit is 1 in the written data. Records whose bits are 0 are left as they were.
- R8: `pend_o[t*16 + n]` is 1 exactly when at least one sender bit is set for number n in interface t's bank.
- R9: Records from different senders for the same number accumulate as separate bits. Repeating a trigger already recorded leaves the bank unchanged.
- R10: Writes to addresses 0x24–0x3C, or to addresses with bits [1:0] nonzero, change no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_if | input | 3 | Index of the writing interface |
| wr_addr | input | 6 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_if | input | 3 | Index of the reading interface (selects the bank) |
| rd_addr | input | 6 | Byte address of the read |
| rd_data | output | 32 | Read data from the selected bank |
| pend_o | output | 128 | Pending flag per interface and interrupt number, index t*16+n |

## Verification
A window read and a trigger write that lands on the same bank and lane can occur in the same cycle. The read must return the record as it was before the write, and the new sender bit must appear only from the next cycle. The bench provokes this by driving a trigger from interface 7 and a read of interface 1's word 1 on the same clock. The scoreboard expects the old lane value in that cycle and the updated lane value one cycle later.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 32;
    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int TGT_LSB = 16;

    typedef enum logic [1:0] {
        ACC_SET  = 2'd0,
        ACC_CLR  = 2'd1,
        ACC_TRIG = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;

    // Classifies a byte address inside the block window.
    function automatic acc_e acc_decode(input logic [ADDR_W-1:0] a);
        acc_e k;
        if (a[1:0] != 2'b00) begin
            k = ACC_NONE;
        end else begin
            case (a[5:4])
                2'd0:    k = ACC_SET;
                2'd1:    k = ACC_CLR;
                2'd2:    k = (a[3:2] == 2'd0) ? ACC_TRIG : ACC_NONE;
                default: k = ACC_NONE;
            endcase
        end
        return k;
    endfunction
endpackage

// File: rtl/sgi_wr_decode.sv
module sgi_wr_decode
    import sgi_pkg::*;
#(
    parameter int NUM_IF = 8,
    parameter int NUM_ID = 16,
    localparam int IF_W = $clog2(NUM_IF),
    localparam int ID_W = $clog2(NUM_ID)
) (
    input  logic                                     wr_en,
    input  logic [IF_W-1:0]                          wr_if,
    input  logic [ADDR_W-1:0]                        wr_addr,
    input  logic [DATA_W-1:0]                        wr_data,
    output logic [NUM_IF-1:0][NUM_ID-1:0][NUM_IF-1:0] set_m,
    output logic [NUM_IF-1:0][NUM_ID-1:0][NUM_IF-1:0] clr_m
);
    acc_e            kind;
    logic [ID_W-1:0] trig_id;
    logic [3:0]      lane_id;

    always_comb begin
        set_m   = '0;
        clr_m   = '0;
        lane_id = '0;
        kind    = acc_decode(wr_addr);
        trig_id = wr_data[ID_W-1:0];
        if (wr_en) begin
            case (kind)
                ACC_TRIG: begin
                    // one sender bit per selected destination
                    for (int t = 0; t < NUM_IF; t++) begin
                        if (wr_data[TGT_LSB+t] && (int'(trig_id) < NUM_ID))
                            set_m[t][trig_id][wr_if] = 1'b1;
                    end
                end
                ACC_SET, ACC_CLR: begin
                    // banked: only the writer's own records are touched
                    for (int b = 0; b < LANES; b++) begin
                        lane_id = {wr_addr[3:2], 2'(b)};
                        if (int'(lane_id) < NUM_ID) begin
                            for (int k = 0; k < NUM_IF; k++) begin
                                if (kind == ACC_SET)
                                    set_m[wr_if][ID_W'(lane_id)][k] = wr_data[b*LANE_W+k];
                                else
                                    clr_m[wr_if][ID_W'(lane_id)][k] = wr_data[b*LANE_W+k];
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank #(
    parameter int NUM_IF = 8,
    parameter int NUM_ID = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_ID-1:0][NUM_IF-1:0] set_i,
    input  logic [NUM_ID-1:0][NUM_IF-1:0] clr_i,
    output logic [NUM_ID-1:0][NUM_IF-1:0] rec_o,
    output logic [NUM_ID-1:0]             any_o
);
    typedef struct packed {
        logic [NUM_ID-1:0][NUM_IF-1:0] rec;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a new record wins over a clear of the same bit
        st_d.rec = (st_q.rec & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rec_o = st_q.rec;

    for (genvar n = 0; n < NUM_ID; n++) begin : g_any
        assign any_o[n] = |st_q.rec[n];
    end

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rec_o == '0));

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((rec_o & $past(set_i)) == $past(set_i)));

    assert_clear_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((rec_o & $past(clr_i & ~set_i)) == '0));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|set_i) && !(|clr_i)) |=> $stable(rec_o));
endmodule

// File: rtl/sgi_rd_mux.sv
module sgi_rd_mux
    import sgi_pkg::*;
#(
    parameter int NUM_IF = 8,
    parameter int NUM_ID = 16,
    localparam int IF_W = $clog2(NUM_IF),
    localparam int ID_W = $clog2(NUM_ID)
) (
    input  logic [NUM_IF-1:0][NUM_ID-1:0][NUM_IF-1:0] banks_i,
    input  logic [IF_W-1:0]                          rd_if,
    input  logic [ADDR_W-1:0]                        rd_addr,
    output logic [DATA_W-1:0]                        rd_data
);
    acc_e       kind;
    logic [3:0] lane_id;

    always_comb begin
        rd_data = '0;
        lane_id = '0;
        kind    = acc_decode(rd_addr);
        if ((kind == ACC_SET || kind == ACC_CLR) && (int'(rd_if) < NUM_IF)) begin
            for (int b = 0; b < LANES; b++) begin
                lane_id = {rd_addr[3:2], 2'(b)};
                if (int'(lane_id) < NUM_ID) begin
                    for (int k = 0; k < NUM_IF; k++)
                        rd_data[b*LANE_W+k] = banks_i[rd_if][ID_W'(lane_id)][k];
                end
            end
        end
    end
endmodule

// File: rtl/sgi_gen.sv
module sgi_gen
    import sgi_pkg::*;
#(
    parameter int NUM_IF = 8,
    parameter int NUM_ID = 16,
    localparam int IF_W = $clog2(NUM_IF)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IF_W-1:0]          wr_if,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [IF_W-1:0]          rd_if,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_IF*NUM_ID-1:0] pend_o
);
    logic [NUM_IF-1:0][NUM_ID-1:0][NUM_IF-1:0] set_m;
    logic [NUM_IF-1:0][NUM_ID-1:0][NUM_IF-1:0] clr_m;
    logic [NUM_IF-1:0][NUM_ID-1:0][NUM_IF-1:0] banks;
    logic [NUM_IF-1:0][NUM_ID-1:0]             any_v;

    sgi_wr_decode #(.NUM_IF(NUM_IF), .NUM_ID(NUM_ID)) u_dec (
        .wr_en   (wr_en),
        .wr_if   (wr_if),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .set_m   (set_m),
        .clr_m   (clr_m)
    );

    for (genvar t = 0; t < NUM_IF; t++) begin : g_bank
        sgi_pend_bank #(.NUM_IF(NUM_IF), .NUM_ID(NUM_ID)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_m[t]),
            .clr_i (clr_m[t]),
            .rec_o (banks[t]),
            .any_o (any_v[t])
        );
        assign pend_o[t*NUM_ID +: NUM_ID] = any_v[t];
    end

    sgi_rd_mux #(.NUM_IF(NUM_IF), .NUM_ID(NUM_ID)) u_rd (
        .banks_i (banks),
        .rd_if   (rd_if),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: tb/sgi_gen_bench.sv
module sgi_gen_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_if = '0;
    logic [5:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [2:0]   rd_if = '0;
    logic [5:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic [127:0] pend_o;

    always #4 clk = ~clk;

    sgi_gen u_sgi_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_if(wr_if),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_if(rd_if),
        .rd_addr(rd_addr), .rd_data(rd_data), .pend_o(pend_o)
    );

    typedef struct {
        bit           is_pend;
        logic [127:0] exp;
        string        tag;
    } item_t;

    item_t      sb_q[$];
    int         pushed = 0;
    int         served = 0;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 0;
    logic [7:0] mdl [8][16];

    function automatic logic [31:0] exp_word(input int ifc, input logic [5:0] a);
        logic [31:0] r = '0;
        if (a[1:0] == 2'b00 && a[5:4] <= 2'd1)
            for (int b = 0; b < 4; b++) r[b*8 +: 8] = mdl[ifc][int'(a[3:2])*4 + b];
        return r;
    endfunction

    function automatic logic [127:0] exp_pend();
        logic [127:0] r = '0;
        for (int t = 0; t < 8; t++)
            for (int n = 0; n < 16; n++) r[t*16+n] = |mdl[t][n];
        return r;
    endfunction

    task automatic model_write(input int src, input logic [5:0] a, input logic [31:0] d);
        if (a == 6'h20) begin
            for (int t = 0; t < 8; t++)
                if (d[16+t]) mdl[t][d[3:0]][src] = 1'b1;
        end else if (a[1:0] == 2'b00 && a[5:4] == 2'd0) begin
            for (int b = 0; b < 4; b++)
                mdl[src][int'(a[3:2])*4+b] = mdl[src][int'(a[3:2])*4+b] | d[b*8 +: 8];
        end else if (a[1:0] == 2'b00 && a[5:4] == 2'd1) begin
            for (int b = 0; b < 4; b++)
                mdl[src][int'(a[3:2])*4+b] = mdl[src][int'(a[3:2])*4+b] & ~d[b*8 +: 8];
        end
    endtask

    // driver: push an expectation and wait for the monitor to judge it
    task automatic push_item(input bit p, input logic [127:0] e, input string tag);
        item_t it;
        it.is_pend = p; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        pushed++;
        wait (served == pushed);
    endtask

    task automatic check_read(input int ifc, input logic [5:0] a, input string tag);
        rd_if = 3'(ifc);
        rd_addr = a;
        push_item(1'b0, {96'b0, exp_word(ifc, a)}, tag);
    endtask

    task automatic check_pend(input string tag);
        push_item(1'b1, exp_pend(), tag);
    endtask

    task automatic do_write(input int src, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_if = 3'(src); wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(src, a, d);
    endtask

    // monitor: pops expectations and compares against the outputs
    initial begin
        forever begin
            item_t it;
            logic [127:0] got;
            wait (sb_q.size() != 0);
            #1;
            it = sb_q.pop_front();
            got = it.is_pend ? pend_o : {96'b0, rd_data};
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
            served++;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 8; t++)
            for (int n = 0; n < 16; n++) mdl[t][n] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_pend("R1 pend after reset");
        for (int w = 0; w < 4; w++) check_read(0, 6'(w*4), "R1 bank0 after reset");
        check_read(5, 6'h1C, "R1 bank5 alias after reset");

        // R2/R4 trigger from if2 to if0 and if2, number 6, stray bits set
        do_write(2, 6'h20, 32'hFF05_FFF6);
        check_read(0, 6'h04, "R2 bank0 word1");
        check_read(2, 6'h04, "R2 bank2 word1");
        check_read(1, 6'h04, "R4 bank1 untouched");
        check_pend("R8 pend after trigger");

        // R5 same-cycle read and trigger (if7 -> if1, number 6)
        @(negedge clk);
        wr_en = 1'b1; wr_if = 3'd7; wr_addr = 6'h20; wr_data = 32'h0002_0006;
        check_read(1, 6'h04, "R5 read before write lands");
        @(negedge clk);
        wr_en = 1'b0;
        model_write(7, 6'h20, 32'h0002_0006);
        check_read(1, 6'h04, "R5 read after write lands");
        check_read(1, 6'h14, "R5 clear alias reads same");

        // R3 empty destination list
        do_write(3, 6'h20, 32'h0000_0009);
        check_pend("R3 empty list no change");
        check_read(3, 6'h08, "R3 bank3 word2");

        // R9 accumulate and idempotent repeat
        do_write(5, 6'h20, 32'h0001_0006);
        check_read(0, 6'h04, "R9 two senders");
        do_write(5, 6'h20, 32'h0001_0006);
        check_read(0, 6'h04, "R9 repeat idempotent");

        // R6 clear own bank only
        do_write(1, 6'h14, 32'h0080_0000);
        check_read(1, 6'h04, "R6 bank1 cleared");
        check_read(0, 6'h04, "R6 bank0 kept");
        do_write(0, 6'h14, 32'h0004_0000);
        check_read(0, 6'h04, "R6 partial clear keeps sender5");
        check_pend("R8 pend after clears");

        // R7 set alias
        do_write(4, 6'h00, 32'h8001_0000);
        check_read(4, 6'h00, "R7 set adds records");
        check_read(3, 6'h00, "R7 other bank untouched");

        // R10 unmapped writes
        do_write(4, 6'h24, 32'hFFFF_FFFF);
        do_write(4, 6'h3C, 32'hFFFF_FFFF);
        do_write(4, 6'h01, 32'hFFFF_FFFF);
        check_pend("R10 unmapped writes no change");
        check_read(4, 6'h00, "R10 bank4 word0");
        check_read(4, 6'h30, "R5 unmapped read zero");

        // R2 highest number and all destinations
        do_write(6, 6'h20, 32'h00FF_000F);
        for (int t = 0; t < 8; t++) check_read(t, 6'h0C, "R2 number 15 all banks");
        check_pend("R8 pend final");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule